// File: doc/BRIEF.md
# Programmable Interval Timer

A memory-mapped interval timer that counts down, one step per clock, from a 32-bit period value. When the count reaches zero, the timer sets a timeout flag and reloads the period. It then either keeps running (continuous mode) or halts (one-shot mode). A single level-sensitive interrupt line reports the timeout flag while the interrupt enable is set. Software clears the flag by writing any value to the status word.

Software reaches the timer over a simple synchronous register bus made of a 2-bit word address, a write strobe, 16-bit write data and registered 16-bit read data. The period is written as two 16-bit halves. Two build parameters change what a period write does. One decides whether the period can be written at all; if not, a write only reloads a fixed build-time value. The other decides whether start/stop control exists; if not, the counter runs from reset and a period write never halts it.

Top module: `pit_timer`

## Requirements
- R1: Register map (word address): 0 = status (bit 0 timeout flag, bit 1 running), 1 = control (bit 0 interrupt enable, bit 1 continuous, bit 2 start, bit 3 stop; start and stop read back as 0), 2 = period bits 15:0, 3 = period bits 31:16. Read data is registered and shows the addressed word one clock after the address is presented. After reset, the flag, the enable and the continuous bit are 0, the period reads the build-time fixed value, and `irq` is low. Running is 0 after reset when start/stop control exists and 1 when it does not.
- R2: With period P loaded and the counter started at clock edge E, the timeout flag and `irq` (enable set) rise after edge E+P+1 and not before.
- R3: In one-shot mode the counter halts at timeout (status running bit clears) and produces no further timeout.
- R4: In continuous mode the counter keeps running after a timeout, and the next timeout follows P+1 clocks after the previous one.
- R5: `irq` is high exactly when the timeout flag and the interrupt enable are both set. Clearing the enable drops `irq` but keeps the flag visible in status.
- R6: A status write of any data clears the timeout flag and drops `irq`, unless a new timeout occurs in the same clock.
- R7: Writing start while the counter is already running neither reloads nor delays it.
- R8: Writing stop halts the count and holds its value. A later start resumes from the held value.
- R9: When one control write sets both start and stop, stop wins and the counter stays halted.
- R10: With start/stop control present and a writable period, a write to either period half stores that half, reloads the counter with the new 32-bit period, and halts the counter.
- R11: Without start/stop control, the counter runs from reset, a period write reloads it and leaves it running, and the start/stop bits have no effect.
- R12: With a fixed period, a period write ignores its data and reloads the counter with the build-time value, and the period words always read back that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register word address |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Registered read data of the word addressed in the previous clock |
| irq | output | 1 | Level interrupt: timeout flag AND interrupt enable |

## Verification
A wrong count or reload value shows up at `irq` as a timeout one or more clocks early or late. The bench therefore samples `irq` in the clock just before and the clock just after each expected expiry, which catches an off-by-one at once. A wrong running state shows up in the status running bit on the next read, and also as a timeout that arrives while the counter should be halted, or never arrives while it should be running. A wrong choice between the build options (halting vs. not halting, storing vs. ignoring period data) gives a timeout whose distance from the period write is wrong, so it is visible within one period of that write.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CTRL   = 2'd1,
    REG_PER_LO = 2'd2,
    REG_PER_HI = 2'd3
  } pit_reg_e;

  localparam int ST_TO_BIT   = 0;
  localparam int ST_RUN_BIT  = 1;
  localparam int CT_IE_BIT   = 0;
  localparam int CT_CONT_BIT = 1;
  localparam int CT_START_BIT = 2;
  localparam int CT_STOP_BIT = 3;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int          HALF_W          = 16,
  parameter bit          WRITABLE_PERIOD = 1'b1,
  parameter int unsigned FIXED_PERIOD    = 40,
  localparam int         CNT_W           = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              we,
  input  logic [HALF_W-1:0] wdata,
  input  logic              running,
  input  logic              expire,
  output logic [HALF_W-1:0] rdata,
  output logic              irq,
  output logic              cont,
  output logic              start_req,
  output logic              stop_req,
  output logic              period_wr,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  period_q
);
  localparam logic [CNT_W-1:0] FIXED_VAL = CNT_W'(FIXED_PERIOD);

  logic wr_status, wr_ctrl, wr_lo, wr_hi;
  logic ie_q, cont_q, to_q;

  always_comb begin
    wr_status = we && (addr == REG_STATUS);
    wr_ctrl   = we && (addr == REG_CTRL);
    wr_lo     = we && (addr == REG_PER_LO);
    wr_hi     = we && (addr == REG_PER_HI);
  end

  assign period_wr = wr_lo || wr_hi;
  assign start_req = wr_ctrl && wdata[CT_START_BIT];
  assign stop_req  = wr_ctrl && wdata[CT_STOP_BIT];
  assign cont      = cont_q;

  generate
    if (WRITABLE_PERIOD) begin : g_wr_period
      logic [CNT_W-1:0] per_q;
      logic [CNT_W-1:0] per_nxt;
      always_comb begin
        per_nxt = per_q;
        if (wr_lo) per_nxt[HALF_W-1:0]     = wdata;
        if (wr_hi) per_nxt[CNT_W-1:HALF_W] = wdata;
      end
      always_ff @(posedge clk) begin
        if (rst)            per_q <= FIXED_VAL;
        else if (period_wr) per_q <= per_nxt;
      end
      assign period_q = per_q;
      assign load_val = per_nxt;
    end else begin : g_fixed_period
      assign period_q = FIXED_VAL;
      assign load_val = FIXED_VAL;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      cont_q <= 1'b0;
    end else if (wr_ctrl) begin
      ie_q   <= wdata[CT_IE_BIT];
      cont_q <= wdata[CT_CONT_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            to_q <= 1'b0;
    else if (expire)    to_q <= 1'b1;
    else if (wr_status) to_q <= 1'b0;
  end

  assign irq = to_q && ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      unique case (pit_reg_e'(addr))
        REG_STATUS: begin
          rdata[ST_TO_BIT]  <= to_q;
          rdata[ST_RUN_BIT] <= running;
        end
        REG_CTRL: begin
          rdata[CT_IE_BIT]   <= ie_q;
          rdata[CT_CONT_BIT] <= cont_q;
        end
        REG_PER_LO: rdata <= period_q[HALF_W-1:0];
        REG_PER_HI: rdata <= period_q[CNT_W-1:HALF_W];
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int          CNT_W          = 32,
  parameter bit          HAS_START_STOP = 1'b1,
  parameter int unsigned FIXED_PERIOD   = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period_q,
  input  logic             cont,
  output logic [CNT_W-1:0] cnt_q,
  output logic             running_q,
  output logic             expire
);
  localparam logic RUN_AT_RESET = !HAS_START_STOP;

  logic run_nxt;

  assign expire = running_q && (cnt_q == '0) && !period_wr;

  always_comb begin
    run_nxt = running_q;
    if (expire && !cont) run_nxt = 1'b0;
    if (HAS_START_STOP) begin
      if (start_req && !running_q) run_nxt = 1'b1;
      if (stop_req)                run_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= CNT_W'(FIXED_PERIOD);
      running_q <= RUN_AT_RESET;
    end else if (period_wr) begin
      cnt_q     <= load_val;
      running_q <= RUN_AT_RESET;
    end else begin
      running_q <= run_nxt;
      if (running_q) begin
        if (cnt_q == '0) cnt_q <= period_q;
        else             cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int          HALF_W          = 16,
  parameter bit          WRITABLE_PERIOD = 1'b1,
  parameter bit          HAS_START_STOP  = 1'b1,
  parameter int unsigned FIXED_PERIOD    = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * HALF_W;

  logic             running_w, expire_w, cont_w;
  logic             start_w, stop_w, period_wr_w;
  logic [CNT_W-1:0] load_w, period_w, cnt_w;

  pit_regs #(
    .HALF_W(HALF_W), .WRITABLE_PERIOD(WRITABLE_PERIOD), .FIXED_PERIOD(FIXED_PERIOD)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .running(running_w), .expire(expire_w), .rdata(bus_rdata), .irq(irq),
    .cont(cont_w), .start_req(start_w), .stop_req(stop_w),
    .period_wr(period_wr_w), .load_val(load_w), .period_q(period_w)
  );

  pit_counter #(
    .CNT_W(CNT_W), .HAS_START_STOP(HAS_START_STOP), .FIXED_PERIOD(FIXED_PERIOD)
  ) u_cnt (
    .clk(clk), .rst(rst), .start_req(start_w), .stop_req(stop_w),
    .period_wr(period_wr_w), .load_val(load_w), .period_q(period_w),
    .cont(cont_w), .cnt_q(cnt_w), .running_q(running_w), .expire(expire_w)
  );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int HALF_W         = 16,
  parameter bit HAS_START_STOP = 1'b1,
  localparam int CNT_W         = 2 * HALF_W
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic             expire,
  input logic             running,
  input logic             cont,
  input logic             start_req,
  input logic             stop_req,
  input logic             period_wr,
  input logic [CNT_W-1:0] cnt
);
  // R2: a running, nonzero count steps down by one
  a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
    (running && cnt != '0 && !period_wr) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R3: one-shot halts at timeout
  a_r3_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
    (expire && !cont && !period_wr) |=> !running);

  // R4: continuous mode stays running through a timeout
  a_r4_cont_runs: assert property (@(posedge clk) disable iff (rst)
    (expire && cont && !stop_req) |=> running);

  // R5: irq can only rise after a timeout or a control write
  a_r5_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(expire) || $past(bus_we && bus_addr == REG_CTRL)));

  // R6: status write without a fresh timeout drops irq
  a_r6_status_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == REG_STATUS && !expire) |=> !irq);

  // R8: a halted counter holds its value
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!running && !period_wr) |=> $stable(cnt));

  generate
    if (HAS_START_STOP) begin : g_ss
      // R9: stop beats start
      a_r9_stop_wins: assert property (@(posedge clk) disable iff (rst)
        (start_req && stop_req) |=> !running);
      // R10: period write halts the counter
      a_r10_period_halts: assert property (@(posedge clk) disable iff (rst)
        period_wr |=> !running);
    end else begin : g_free
      // R11: period write keeps the counter running
      a_r11_period_runs: assert property (@(posedge clk) disable iff (rst)
        period_wr |=> running);
    end
  endgenerate
endmodule

bind pit_timer pit_timer_chk #(
  .HALF_W(HALF_W), .HAS_START_STOP(HAS_START_STOP)
) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .bus_we(bus_we), .bus_addr(bus_addr),
  .expire(expire_w), .running(running_w), .cont(cont_w),
  .start_req(start_w), .stop_req(stop_w), .period_wr(period_wr_w), .cnt(cnt_w)
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  localparam int FIX = 24;
  localparam int P   = 10;
  localparam int Q   = 6;
  // instance index: 0 writable+startstop, 1 fixed+startstop, 2 writable+free, 3 fixed+free
  localparam int D_MAIN = 0, D_FIX = 1, D_FREE = 2, D_BOTH = 3;
  localparam logic [1:0] A_ST = 2'd0, A_CT = 2'd1, A_LO = 2'd2, A_HI = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr [4];
  logic        we   [4];
  logic [15:0] wdata[4];
  logic [15:0] rdata[4];
  logic        irq  [4];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pit_timer #(.WRITABLE_PERIOD(1'b1), .HAS_START_STOP(1'b1), .FIXED_PERIOD(FIX)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr[0]), .bus_we(we[0]), .bus_wdata(wdata[0]),
    .bus_rdata(rdata[0]), .irq(irq[0]));
  pit_timer #(.WRITABLE_PERIOD(1'b0), .HAS_START_STOP(1'b1), .FIXED_PERIOD(FIX)) u_dut_fix (
    .clk(clk), .rst(rst), .bus_addr(addr[1]), .bus_we(we[1]), .bus_wdata(wdata[1]),
    .bus_rdata(rdata[1]), .irq(irq[1]));
  pit_timer #(.WRITABLE_PERIOD(1'b1), .HAS_START_STOP(1'b0), .FIXED_PERIOD(FIX)) u_dut_free (
    .clk(clk), .rst(rst), .bus_addr(addr[2]), .bus_we(we[2]), .bus_wdata(wdata[2]),
    .bus_rdata(rdata[2]), .irq(irq[2]));
  pit_timer #(.WRITABLE_PERIOD(1'b0), .HAS_START_STOP(1'b0), .FIXED_PERIOD(FIX)) u_dut_both (
    .clk(clk), .rst(rst), .bus_addr(addr[3]), .bus_we(we[3]), .bus_wdata(wdata[3]),
    .bus_rdata(rdata[3]), .irq(irq[3]));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int d, input logic [1:0] a, input logic [15:0] v);
    addr[d] = a; wdata[d] = v; we[d] = 1'b1;
    @(negedge clk);
    we[d] = 1'b0;
  endtask

  task automatic rd(input int d, input logic [1:0] a, output logic [15:0] v);
    addr[d] = a;
    @(negedge clk);
    v = rdata[d];
  endtask

  // irq must be low for n-1 more clocks and high on the next one
  task automatic expect_fire(input int d, input int n, input string req);
    step(n - 1);
    chk({req, " irq before timeout"}, 32'(irq[d]), 32'd0);
    step(1);
    chk({req, " irq at timeout"}, 32'(irq[d]), 32'd1);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 irq", 32'(irq[D_MAIN]), 32'd0);
    rd(D_MAIN, A_ST, v); chk("R1 status", 32'(v), 32'd0);
    rd(D_MAIN, A_CT, v); chk("R1 control", 32'(v), 32'd0);
    rd(D_MAIN, A_LO, v); chk("R1 period lo", 32'(v), 32'(FIX));
    rd(D_MAIN, A_HI, v); chk("R1 period hi", 32'(v), 32'd0);
    rd(D_FREE, A_ST, v); chk("R1 free runs from reset", 32'(v), 32'd2);
  endtask

  task automatic t_oneshot;
    logic [15:0] v;
    wr(D_MAIN, A_LO, 16'(P));
    wr(D_MAIN, A_CT, 16'h5);
    expect_fire(D_MAIN, P + 1, "R2");
    rd(D_MAIN, A_ST, v); chk("R3 halted with flag", 32'(v), 32'd1);
    wr(D_MAIN, A_CT, 16'h0);
    chk("R5 irq masked", 32'(irq[D_MAIN]), 32'd0);
    rd(D_MAIN, A_ST, v); chk("R5 flag kept", 32'(v), 32'd1);
    wr(D_MAIN, A_CT, 16'h1);
    chk("R5 irq unmasked", 32'(irq[D_MAIN]), 32'd1);
    wr(D_MAIN, A_ST, 16'hBEEF);
    chk("R6 irq cleared", 32'(irq[D_MAIN]), 32'd0);
    rd(D_MAIN, A_ST, v); chk("R6 flag cleared", 32'(v), 32'd0);
    step(2 * P);
    chk("R3 no refire", 32'(irq[D_MAIN]), 32'd0);
  endtask

  task automatic t_cont;
    logic [15:0] v;
    wr(D_MAIN, A_CT, 16'h7);
    expect_fire(D_MAIN, P + 1, "R4 first");
    wr(D_MAIN, A_ST, 16'h0);
    chk("R6 cleared in continuous", 32'(irq[D_MAIN]), 32'd0);
    expect_fire(D_MAIN, P, "R4 second");
    rd(D_MAIN, A_ST, v); chk("R4 still running", 32'(v), 32'd3);
    wr(D_MAIN, A_CT, 16'h9);
    wr(D_MAIN, A_ST, 16'h0);
  endtask

  task automatic t_restart;
    wr(D_MAIN, A_LO, 16'(P));
    wr(D_MAIN, A_CT, 16'h7);
    step(2);
    wr(D_MAIN, A_CT, 16'h7);
    expect_fire(D_MAIN, P - 2, "R7");
    wr(D_MAIN, A_CT, 16'h9);
    wr(D_MAIN, A_ST, 16'h0);
  endtask

  task automatic t_hold;
    logic [15:0] v;
    wr(D_MAIN, A_LO, 16'(P));
    wr(D_MAIN, A_CT, 16'h5);
    step(2);
    wr(D_MAIN, A_CT, 16'h9);
    step(3 * P);
    chk("R8 halted no irq", 32'(irq[D_MAIN]), 32'd0);
    rd(D_MAIN, A_ST, v); chk("R8 running clear", 32'(v), 32'd0);
    wr(D_MAIN, A_CT, 16'h5);
    expect_fire(D_MAIN, P - 2, "R8 resume");
    wr(D_MAIN, A_ST, 16'h0);
  endtask

  task automatic t_both_bits;
    logic [15:0] v;
    wr(D_MAIN, A_CT, 16'hD);
    step(2 * P);
    chk("R9 no irq", 32'(irq[D_MAIN]), 32'd0);
    rd(D_MAIN, A_ST, v); chk("R9 stays halted", 32'(v), 32'd0);
  endtask

  task automatic t_period;
    logic [15:0] v;
    wr(D_MAIN, A_CT, 16'h7);
    step(3);
    wr(D_MAIN, A_LO, 16'(Q));
    step(2 * P);
    chk("R10 halted no irq", 32'(irq[D_MAIN]), 32'd0);
    rd(D_MAIN, A_ST, v); chk("R10 running clear", 32'(v), 32'd0);
    rd(D_MAIN, A_LO, v); chk("R10 lo stored", 32'(v), 32'(Q));
    rd(D_MAIN, A_HI, v); chk("R10 hi unchanged", 32'(v), 32'd0);
    wr(D_MAIN, A_CT, 16'h7);
    expect_fire(D_MAIN, Q + 1, "R10 new period");
    wr(D_MAIN, A_HI, 16'h0001);
    rd(D_MAIN, A_HI, v); chk("R10 hi stored", 32'(v), 32'd1);
    rd(D_MAIN, A_ST, v); chk("R10 hi write halts", 32'(v), 32'd1);
    wr(D_MAIN, A_HI, 16'h0000);
    wr(D_MAIN, A_ST, 16'h0);
  endtask

  task automatic t_free;
    logic [15:0] v;
    wr(D_FREE, A_ST, 16'h0);
    wr(D_FREE, A_LO, 16'(P));
    wr(D_FREE, A_CT, 16'h3);
    expect_fire(D_FREE, P, "R11 run after period write");
    wr(D_FREE, A_ST, 16'h0);
    step(2);
    wr(D_FREE, A_LO, 16'(P));
    expect_fire(D_FREE, P + 1, "R11 reload keeps running");
    rd(D_FREE, A_ST, v); chk("R11 running after timeout", 32'(v), 32'd3);
    wr(D_FREE, A_CT, 16'hB);
    rd(D_FREE, A_ST, v); chk("R11 stop ignored", 32'((v >> 1) & 16'h1), 32'd1);
  endtask

  task automatic t_fixed;
    logic [15:0] v;
    wr(D_FIX, A_LO, 16'h0005);
    rd(D_FIX, A_LO, v); chk("R12 lo ignores data", 32'(v), 32'(FIX));
    rd(D_FIX, A_ST, v); chk("R12 halted after write", 32'(v), 32'd0);
    wr(D_FIX, A_CT, 16'h5);
    expect_fire(D_FIX, FIX + 1, "R12 fixed reload");
    wr(D_BOTH, A_ST, 16'h0);
    wr(D_BOTH, A_LO, 16'h0003);
    wr(D_BOTH, A_CT, 16'h1);
    expect_fire(D_BOTH, FIX, "R12 fixed free-running");
    rd(D_BOTH, A_ST, v); chk("R12 one-shot halted", 32'(v), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      addr[i] = 2'd0; we[i] = 1'b0; wdata[i] = 16'h0;
    end
    step(4);
    rst = 1'b0;
    t_reset();
    t_oneshot();
    t_cont();
    t_restart();
    t_hold();
    t_both_bits();
    t_period();
    t_free();
    t_fixed();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule